// File: doc/BRIEF.md
# Password Verifier with Retry-Erase Counter

This block checks access passwords for a secure serial memory. It holds two 64-bit passwords, one that opens reads and one that opens writes. The serial front end loads a candidate password one byte at a time. The verifier compares it against the password chosen by the command at the start of the transaction. Every completed load starts a forced nonvolatile write cycle, whether the candidate was right or wrong. This makes each guess slow. The result becomes visible only through acknowledge polling, and only after that cycle has finished.

Failed attempts accumulate in a retry counter, in any mix of read and write attempts. When the counter reaches its limit, the block raises a one-cycle erase request, clears both stored passwords to zero and restarts the count. A correct attempt made before that point clears the counter. The stored passwords are kept as a register model whose reset value is a parameter, all zeros by default. The data array, the bus framing and password changes are handled elsewhere.

Top module: `pwd_guard`

## Requirements
- R1: After reset, grant, poll_rsp, poll_ack, erase_req and nv_req are all 0, the retry count is 0, and the read and write passwords hold RD_INIT and WR_INIT.
- R2: The password kind is sampled from sel_write when txn_start is high: 0 selects the read password and 1 selects the write password. The first byte loaded is compared with bits [63:56] and each later byte with the next lower byte.
- R3: When pw_done is accepted, nv_req is 1 in the next cycle only, and the write cycle starts whether the candidate is right or wrong.
- R4: The write cycle lasts at least NV_CYCLES clocks and ends only once nv_done is seen high after that. While it runs, pw_valid and pw_done are ignored and polls get NACK.
- R5: A poll strobe gives poll_rsp = 1 in the next cycle. poll_ack is 1 only if the code is 0x55, no write cycle is running, and the most recent accepted attempt was correct. Any other code gets poll_ack = 0.
- R6: After a wrong attempt, every poll returns NACK, however long after the write cycle ended.
- R7: grant rises with an acknowledged poll and falls on the cycle after txn_start or txn_stop.
- R8: A correct attempt resets the retry count to 0, so earlier failures no longer count towards the erase.
- R9: The eighth failure counted since reset or since the last correct attempt raises erase_req for exactly one cycle, the cycle after that pw_done.
- R10: After the erase, both passwords are zero: an all-zero candidate is accepted for reads and writes, and the old passwords are rejected.
- R11: A candidate is correct only if exactly 8 bytes were loaded. Seven bytes, or a ninth byte, make the attempt wrong even when the bytes match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | A new transaction begins; samples sel_write, clears grant and load progress |
| txn_stop | input | 1 | The transaction ends; clears grant and load progress |
| sel_write | input | 1 | Password kind: 0 = read, 1 = write |
| pw_valid | input | 1 | pw_byte holds one candidate byte |
| pw_byte | input | BYTE_W | Candidate password byte |
| pw_done | input | 1 | End of the password load; evaluate the candidate |
| poll_valid | input | 1 | Acknowledge-poll command strobe |
| poll_code | input | BYTE_W | Command code of the poll |
| nv_done | input | 1 | The storage reports that the nonvolatile cycle is finished |
| grant | output | 1 | Access granted for the current transaction |
| poll_rsp | output | 1 | A poll response is valid this cycle |
| poll_ack | output | 1 | Poll answered with ACK (1) or NACK (0) |
| erase_req | output | 1 | One-cycle request to wipe the array and both passwords |
| nv_req | output | 1 | One-cycle request to start the forced write cycle |

## Verification
The hardest state to reach is the erase that is owed only to failures accumulated since the last success. The counter cannot be read from the ports. The stimulus therefore makes seven failures, one correct attempt and then seven more failures, and expects no erase. One further failure must then produce exactly one erase pulse. After that, all-zero candidates must be accepted and the old passwords rejected. A load issued during a running write cycle is also driven, and the next poll shows it had no effect. The bench runs a behavioural queue-based model every clock.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
    localparam int unsigned PWG_BYTE_W      = 8;
    localparam int unsigned PWG_BYTES       = 8;
    localparam int unsigned PWG_RETRY_LIMIT = 8;
    localparam logic [7:0]  PWG_POLL_CODE   = 8'h55;

    typedef enum logic {
        SEL_READ  = 1'b0,
        SEL_WRITE = 1'b1
    } pw_sel_e;
endpackage

// File: rtl/pwg_store.sv
// Register model of the two stored passwords, wiped together on request.
module pwg_store
    import pwg_pkg::*;
#(
    parameter int unsigned     PW_W    = 64,
    parameter logic [PW_W-1:0] RD_INIT = '0,
    parameter logic [PW_W-1:0] WR_INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wipe_i,
    input  pw_sel_e         sel_i,
    output logic [PW_W-1:0] pw_o
);
    localparam int unsigned SLOTS = 2;

    logic [PW_W-1:0] slot_val [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam logic [PW_W-1:0] INIT = (s == 0) ? RD_INIT : WR_INIT;
        logic [PW_W-1:0] pw_d, pw_q;

        always_comb begin
            pw_d = pw_q;
            if (wipe_i) pw_d = '0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pw_q <= INIT;
            else        pw_q <= pw_d;
        end

        assign slot_val[s] = pw_q;
    end

    assign pw_o = (sel_i == SEL_WRITE) ? slot_val[1] : slot_val[0];
endmodule

// File: rtl/pwg_compare.sv
// Byte-serial comparison into a running match flag with an exact byte count.
module pwg_compare #(
    parameter int unsigned BYTES  = 8,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart_i,
    input  logic                    byte_vld_i,
    input  logic [BYTE_W-1:0]       byte_i,
    input  logic [BYTES*BYTE_W-1:0] ref_pw_i,
    output logic                    match_o
);
    localparam int unsigned CNT_W = $clog2(BYTES + 1);
    localparam int unsigned IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             same;
        logic             extra;
    } cmp_t;

    cmp_t d, q;
    logic [BYTE_W-1:0] ref_byte [BYTES];

    // first byte on the wire is the most significant byte
    for (genvar b = 0; b < BYTES; b++) begin : g_split
        assign ref_byte[b] = ref_pw_i[(BYTES-1-b)*BYTE_W +: BYTE_W];
    end

    always_comb begin
        d = q;
        if (restart_i) begin
            d.cnt   = '0;
            d.same  = 1'b1;
            d.extra = 1'b0;
        end else if (byte_vld_i) begin
            if (q.cnt == FULL) begin
                d.extra = 1'b1;
            end else begin
                if (byte_i != ref_byte[q.cnt[IDX_W-1:0]]) d.same = 1'b0;
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt   <= '0;
            q.same  <= 1'b1;
            q.extra <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign match_o = (q.cnt == FULL) && q.same && !q.extra;
endmodule

// File: rtl/pwg_retry.sv
// Failure counter; reaching the limit holds one cycle as the erase request.
module pwg_retry #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_i,
    input  logic pass_i,
    output logic erase_o
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q == TOP)  cnt_d = '0;
        else if (pass_i)   cnt_d = '0;
        else if (fail_i)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign erase_o = (cnt_q == TOP);
endmodule

// File: rtl/pwg_nvtimer.sv
// Forced write-cycle window: minimum length in clocks, then wait for done.
module pwg_nvtimer #(
    parameter int unsigned NV_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    output logic busy_o,
    output logic req_o
);
    localparam int unsigned TW = $clog2(NV_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(NV_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic          req;
        logic [TW-1:0] tmr;
    } nv_t;

    nv_t d, q;

    always_comb begin
        d     = q;
        d.req = 1'b0;
        if (start_i && !q.busy) begin
            d.busy = 1'b1;
            d.req  = 1'b1;
            d.tmr  = '0;
        end else if (q.busy) begin
            if (q.tmr >= LAST && done_i) d.busy = 1'b0;
            else if (q.tmr < LAST)       d.tmr  = q.tmr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.busy;
    assign req_o  = q.req;
endmodule

// File: rtl/pwd_guard.sv
module pwd_guard
    import pwg_pkg::*;
#(
    parameter int unsigned BYTE_W      = PWG_BYTE_W,
    parameter int unsigned PW_BYTES    = PWG_BYTES,
    parameter int unsigned RETRY_LIMIT = PWG_RETRY_LIMIT,
    parameter int unsigned NV_CYCLES   = 500000,
    parameter logic [BYTE_W-1:0] POLL_CODE = BYTE_W'(PWG_POLL_CODE),
    parameter logic [PW_BYTES*BYTE_W-1:0] RD_INIT = '0,
    parameter logic [PW_BYTES*BYTE_W-1:0] WR_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              txn_stop,
    input  logic              sel_write,
    input  logic              pw_valid,
    input  logic [BYTE_W-1:0] pw_byte,
    input  logic              pw_done,
    input  logic              poll_valid,
    input  logic [BYTE_W-1:0] poll_code,
    input  logic              nv_done,
    output logic              grant,
    output logic              poll_rsp,
    output logic              poll_ack,
    output logic              erase_req,
    output logic              nv_req
);
    localparam int unsigned PW_W = PW_BYTES * BYTE_W;

    typedef struct packed {
        pw_sel_e sel;
        logic    ok;
        logic    tried;
        logic    grant;
        logic    rsp;
        logic    ack;
    } ctl_t;

    ctl_t d, q;

    logic            nv_busy;
    logic            wiping;
    logic            gate;
    logic            take_byte;
    logic            finish;
    logic            verdict;
    logic            restart;
    logic [PW_W-1:0] ref_pw;

    assign gate      = !nv_busy && !wiping && !txn_start && !txn_stop;
    assign take_byte = gate && pw_valid && !pw_done;
    assign finish    = gate && pw_done;
    assign restart   = txn_start || txn_stop || finish;

    pwg_store #(
        .PW_W    (PW_W),
        .RD_INIT (RD_INIT),
        .WR_INIT (WR_INIT)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wipe_i (wiping),
        .sel_i  (q.sel),
        .pw_o   (ref_pw)
    );

    pwg_compare #(
        .BYTES  (PW_BYTES),
        .BYTE_W (BYTE_W)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .byte_vld_i (take_byte),
        .byte_i     (pw_byte),
        .ref_pw_i   (ref_pw),
        .match_o    (verdict)
    );

    pwg_retry #(
        .LIMIT (RETRY_LIMIT)
    ) u_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .fail_i  (finish && !verdict),
        .pass_i  (finish && verdict),
        .erase_o (wiping)
    );

    pwg_nvtimer #(
        .NV_CYCLES (NV_CYCLES)
    ) u_nv (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (finish),
        .done_i  (nv_done),
        .busy_o  (nv_busy),
        .req_o   (nv_req)
    );

    always_comb begin
        d     = q;
        d.rsp = 1'b0;
        d.ack = 1'b0;
        if (finish) begin
            d.ok    = verdict;
            d.tried = 1'b1;
        end
        if (poll_valid) begin
            d.rsp = 1'b1;
            d.ack = (poll_code == POLL_CODE) && !nv_busy && q.ok && q.tried;
        end
        if (d.ack) d.grant = 1'b1;
        if (txn_start) begin
            d.sel   = sel_write ? SEL_WRITE : SEL_READ;
            d.grant = 1'b0;
        end else if (txn_stop) begin
            d.grant = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sel   <= SEL_READ;
            q.ok    <= 1'b0;
            q.tried <= 1'b0;
            q.grant <= 1'b0;
            q.rsp   <= 1'b0;
            q.ack   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign grant     = q.grant;
    assign poll_rsp  = q.rsp;
    assign poll_ack  = q.ack;
    assign erase_req = wiping;
endmodule

// File: rtl/pwd_guard_chk.sv
module pwd_guard_chk #(
    parameter int unsigned       BYTE_W    = 8,
    parameter logic [BYTE_W-1:0] POLL_CODE = 8'h55
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txn_start,
    input logic              txn_stop,
    input logic              pw_done,
    input logic              poll_valid,
    input logic [BYTE_W-1:0] poll_code,
    input logic              grant,
    input logic              poll_rsp,
    input logic              poll_ack,
    input logic              erase_req,
    input logic              nv_req,
    input logic              nv_busy
);
    // R3
    nv_req_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_done && !nv_busy && !erase_req && !txn_start && !txn_stop) |=> nv_req);

    // R3
    nv_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |=> !nv_req);

    // R4
    ignore_done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_done && nv_busy) |=> !nv_req);

    // R4
    poll_busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_valid && nv_busy) |=> !poll_ack);

    // R5
    ack_has_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_ack |-> poll_rsp);

    // R5
    illegal_code_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_valid && poll_code != POLL_CODE) |=> !poll_ack);

    // R7
    grant_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start || txn_stop) |=> !grant);

    // R9
    erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);

    // R9
    erase_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> nv_busy);
endmodule

bind pwd_guard pwd_guard_chk #(
    .BYTE_W    (BYTE_W),
    .POLL_CODE (POLL_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_start  (txn_start),
    .txn_stop   (txn_stop),
    .pw_done    (pw_done),
    .poll_valid (poll_valid),
    .poll_code  (poll_code),
    .grant      (grant),
    .poll_rsp   (poll_rsp),
    .poll_ack   (poll_ack),
    .erase_req  (erase_req),
    .nv_req     (nv_req),
    .nv_busy    (nv_busy)
);

// File: tb/sim_pwd_guard.sv
`timescale 1ns/1ps
module sim_pwd_guard;
    localparam int          NV  = 20;
    localparam logic [63:0] RDP = 64'h1122_3344_5566_7788;
    localparam logic [63:0] WRP = 64'hA1B2_C3D4_E5F6_0718;
    localparam logic [63:0] BAD = 64'hDEAD_BEEF_0BAD_F00D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_start = 0, txn_stop = 0, sel_write = 0;
    logic pw_valid = 0, pw_done = 0, poll_valid = 0, nv_done = 1;
    logic [7:0] pw_byte = '0, poll_code = '0;
    logic grant, poll_rsp, poll_ack, erase_req, nv_req;

    always #10 clk = ~clk;

    pwd_guard #(
        .NV_CYCLES (NV),
        .RD_INIT   (RDP),
        .WR_INIT   (WRP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_stop(txn_stop),
        .sel_write(sel_write), .pw_valid(pw_valid), .pw_byte(pw_byte),
        .pw_done(pw_done), .poll_valid(poll_valid), .poll_code(poll_code),
        .nv_done(nv_done), .grant(grant), .poll_rsp(poll_rsp),
        .poll_ack(poll_ack), .erase_req(erase_req), .nv_req(nv_req)
    );

    int n_chk = 0, n_bad = 0, er_cnt = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_pw [2];
    byte unsigned m_q[$];
    int  m_retry, m_timer;
    bit  m_busy, m_ok, m_tried, m_sel, m_grant, m_prsp, m_pack, m_nvreq;
    bit  o_busy, o_erase, m_gate, m_good;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pw[0] = RDP; m_pw[1] = WRP; m_q.delete();
            m_retry = 0; m_timer = 0; m_busy = 0; m_ok = 0; m_tried = 0;
            m_sel = 0; m_grant = 0; m_prsp = 0; m_pack = 0; m_nvreq = 0;
        end else begin
            o_busy  = m_busy;
            o_erase = (m_retry == 8);
            m_gate  = !o_busy && !o_erase && !txn_start && !txn_stop;
            m_prsp = 0; m_pack = 0; m_nvreq = 0;
            if (poll_valid) begin
                m_prsp = 1;
                m_pack = (poll_code == 8'h55) && !o_busy && m_ok && m_tried;
            end
            if (o_busy) begin
                if (m_timer >= NV - 1 && nv_done) m_busy = 0;
                else if (m_timer < NV - 1) m_timer++;
            end
            if (m_gate && pw_done) begin
                m_good = (m_q.size() == 8);
                foreach (m_q[i]) if (m_q[i] != m_pw[m_sel][63-8*i -: 8]) m_good = 0;
                m_ok = m_good; m_tried = 1;
                m_busy = 1; m_timer = 0; m_nvreq = 1;
                m_retry = m_good ? 0 : m_retry + 1;
                m_q.delete();
            end else if (m_gate && pw_valid) begin
                m_q.push_back(pw_byte);
            end
            if (m_pack) m_grant = 1;
            if (txn_start) begin
                m_grant = 0; m_sel = sel_write; m_q.delete();
            end else if (txn_stop) begin
                m_grant = 0; m_q.delete();
            end
            if (o_erase) begin
                m_retry = 0; m_pw[0] = '0; m_pw[1] = '0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(grant == m_grant,               "R7 grant vs model",    64'(grant),     64'(m_grant));
            chk(poll_rsp == m_prsp,             "R5 poll_rsp vs model", 64'(poll_rsp),  64'(m_prsp));
            chk(poll_ack == m_pack,             "R6 poll_ack vs model", 64'(poll_ack),  64'(m_pack));
            chk(erase_req == (m_retry == 8),    "R9 erase vs model",    64'(erase_req), 64'(m_retry == 8));
            chk(nv_req == m_nvreq,              "R3 nv_req vs model",   64'(nv_req),    64'(m_nvreq));
            if (erase_req) er_cnt++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_pw(input bit sel, input logic [63:0] pw, input int nbytes,
                           input bit exp_nv, input bit exp_er);
        @(negedge clk); txn_start = 1; sel_write = sel;
        @(negedge clk); txn_start = 0;
        for (int i = 0; i < nbytes; i++) begin
            pw_valid = 1; pw_byte = pw[63-8*(i%8) -: 8];
            @(negedge clk);
        end
        pw_valid = 0; pw_done = 1;
        @(negedge clk); pw_done = 0;
        chk(nv_req == exp_nv,    "R3 write cycle request", 64'(nv_req),    64'(exp_nv));
        chk(erase_req == exp_er, "R9 erase request",       64'(erase_req), 64'(exp_er));
        txn_stop = 1;
        @(negedge clk); txn_stop = 0;
    endtask

    task automatic poll(input logic [7:0] code, input bit exp_ack, input string tag);
        @(negedge clk); txn_start = 1;
        @(negedge clk); txn_start = 0; poll_valid = 1; poll_code = code;
        @(negedge clk); poll_valid = 0;
        chk(poll_rsp == 1'b1,    "R5 poll response",  64'(poll_rsp), 64'd1);
        chk(poll_ack == exp_ack, tag,                 64'(poll_ack), 64'(exp_ack));
        chk(grant == exp_ack,    "R7 grant on poll",  64'(grant),    64'(exp_ack));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst_n = 1;
        @(negedge clk);
        chk(grant == 0,     "R1 reset grant",   64'(grant),     64'd0);
        chk(poll_ack == 0,  "R1 reset ack",     64'(poll_ack),  64'd0);
        chk(poll_rsp == 0,  "R1 reset rsp",     64'(poll_rsp),  64'd0);
        chk(erase_req == 0, "R1 reset erase",   64'(erase_req), 64'd0);
        chk(nv_req == 0,    "R1 reset nv_req",  64'(nv_req),    64'd0);

        // correct read password, storage holds the cycle open
        nv_done = 0;
        send_pw(0, RDP, 8, 1, 0);
        poll(8'h55, 0, "R4 poll during write cycle");
        wait_n(NV + 6);
        poll(8'h55, 0, "R4 cycle held until nv_done");
        nv_done = 1;
        wait_n(2);
        poll(8'h55, 1, "R2 read password accepted");
        txn_stop = 1; @(negedge clk); txn_stop = 0;
        @(negedge clk);
        chk(grant == 0, "R7 grant cleared by stop", 64'(grant), 64'd0);

        send_pw(1, WRP, 8, 1, 0); wait_n(NV + 4);
        poll(8'h55, 1, "R2 write password accepted");
        poll(8'hAA, 0, "R5 illegal poll code");

        send_pw(1, RDP, 8, 1, 0); wait_n(NV + 4);          // failure 1
        poll(8'h55, 0, "R2 read password on write select");
        send_pw(0, BAD, 8, 1, 0); wait_n(3 * NV);          // failure 2
        poll(8'h55, 0, "R6 wrong password late poll");
        poll(8'h55, 0, "R6 wrong password repeat poll");
        send_pw(0, RDP, 7, 1, 0); wait_n(NV + 4);          // failure 3
        poll(8'h55, 0, "R11 seven bytes");
        send_pw(0, RDP, 9, 1, 0); wait_n(NV + 4);          // failure 4
        poll(8'h55, 0, "R11 nine bytes");
        send_pw(0, RDP, 8, 1, 0); wait_n(NV + 4);
        poll(8'h55, 1, "R8 correct after failures");

        for (int k = 0; k < 7; k++) begin
            send_pw(k[0], BAD, 8, 1, 0); wait_n(NV + 4);
        end
        send_pw(1, WRP, 8, 1, 0); wait_n(NV + 4);
        poll(8'h55, 1, "R8 passwords intact after seven failures");
        for (int k = 0; k < 7; k++) begin
            send_pw(k[0], BAD, 8, 1, 0); wait_n(NV + 4);
        end
        chk(er_cnt == 0, "R8 count restarted by success", 64'(er_cnt), 64'd0);
        send_pw(1, BAD, 8, 1, 1); wait_n(NV + 4);
        chk(er_cnt == 1, "R9 single erase pulse", 64'(er_cnt), 64'd1);

        poll(8'h55, 0, "R10 nack after erase");
        send_pw(0, RDP, 8, 1, 0); wait_n(NV + 4);
        poll(8'h55, 0, "R10 old read password rejected");
        send_pw(0, 64'h0, 8, 1, 0); wait_n(NV + 4);
        poll(8'h55, 1, "R10 zero read password accepted");
        send_pw(1, 64'h0, 8, 1, 0); wait_n(NV + 4);
        poll(8'h55, 1, "R10 zero write password accepted");

        send_pw(0, 64'h1, 8, 1, 0);
        send_pw(0, 64'h0, 8, 0, 0);                        // issued while busy
        wait_n(NV + 4);
        poll(8'h55, 0, "R4 load during write cycle ignored");

        wait_n(3);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule